// File: doc/BRIEF.md
# Line-Locked Pixel Clock Generator

This block makes a pixel-rate enable pulse, running from a fast reference clock, and keeps it phase-locked to a horizontal sync input. The divisor that sets the pixel period is stored in eighths of a fast-clock period. A phase accumulator adds eight on every fast clock. When the accumulator reaches the divisor, the block emits one enable pulse and subtracts the divisor. The fraction carried into the next period is capped at seven.

On each sync rising edge the block compares the number of pixel pulses counted in the finished line against the expected count. The expected count is twelve times an odd number taken from the line-duration field. The signed difference drives a proportional-plus-difference loop filter, whose output is saturated, and the filter writes a new divisor. The block has two shift-constant pairs. A slow pair is used while locked and a fast pair while capturing. Lock is declared after four consecutive lines within two pixels of the target. A load strobe seeds the divisor from a programmed initial period, so the loop settles quickly after the line rate changes.

Top module: `line_lock_pll`

## Requirements
- R1: The expected pixel count per line is 12·(2·line_len + 1). The line error is the number of pix_en pulses seen from the previous hsync rising edge up to and including the cycle of the current one, minus that count.
- R2: pix_en is high for single cycles only. Successive pulses, and the first pulse after a load, are 2 to 16 cycles apart. With a divisor that is an exact multiple of 8, pulses come every div/8 cycles.
- R3: On each measured line the new divisor is div + (err >>> a) + ((err − err_prev) >>> b), using arithmetic shifts. It appears on div two cycles after the cycle in which hsync is first seen high.
- R4: The divisor is saturated to the range 20..128 after every update.
- R5: locked rises after the update of the fourth consecutive line with |err| ≤ 2, and not before.
- R6: A line with |err| > 2 clears locked at its update and restarts the good-line count.
- R7: The shift pair (a, b) is (lock_a, lock_b) when locked was high before the line's update, and (cap_a, cap_b) otherwise.
- R8: rst or pp_wr loads div with pp_val clamped to 20..128 on the next cycle, clears locked, sets err_prev to 0 and restarts the phase accumulator and the pixel count.
- R9: div changes only through a line update (R3) or a load (R8).
- R10: The first hsync rising edge after a load or reset only starts the pixel count. It leaves div and locked unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high, acts as a load of pp_val |
| hsync | input | 1 | Horizontal sync, synchronous to clk, rising edge marks a line |
| line_len | input | 6 | Line-duration field for the expected pixel count |
| pp_val | input | 8 | Initial pixel period in eighths of a fast clock |
| pp_wr | input | 1 | One-cycle strobe that loads pp_val into the divisor |
| lock_a | input | 3 | Error shift used while locked |
| lock_b | input | 3 | Error-difference shift used while locked |
| cap_a | input | 3 | Error shift used while capturing |
| cap_b | input | 3 | Error-difference shift used while capturing |
| pix_en | output | 1 | Pixel-rate enable pulse |
| locked | output | 1 | High while the loop is in lock mode |
| div | output | 8 | Current divisor in eighths of a fast clock |

## Verification
The bound checker tests the following on every cycle: pulse spacing stays within its bounds, the divisor stays inside its range, the divisor holds between updates, a load takes effect on the next cycle, a bad line drops lock, and lock rises only on an update. Only the bench scenarios can show the arithmetic. They check the error against 12·(2·line_len + 1), the exact filter value under each constant pair, that lock needs exactly four good lines, that the first edge after a load only primes the count, and that the divisor saturates at both ends. The bench predicts each divisor from the pulses it counts at the ports between sync edges.

// File: rtl/lpll_pkg.sv
package lpll_pkg;
    localparam int LD_W_DEF       = 6;
    localparam int PP_W_DEF       = 8;
    localparam int K_W_DEF        = 3;
    localparam int FRAC_BITS_DEF  = 3;
    localparam int D_MIN_DEF      = 20;
    localparam int D_MAX_DEF      = 128;
    localparam int TOL_DEF        = 2;
    localparam int LOCK_LINES_DEF = 4;
    localparam int CNT_W_DEF      = 11;
    localparam int PX_PER_UNIT    = 12;

    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_LOCK    = 1'b1
    } loop_mode_e;
endpackage

// File: rtl/lpll_nco.sv
module lpll_nco #(
    parameter int D_W       = 8,
    parameter int FRAC_BITS = 3
) (
    input  logic           clk,
    input  logic           clr,
    input  logic [D_W-1:0] div_i,
    output logic           pix_en_o
);
    localparam int ACC_W = D_W + 1;
    localparam logic [ACC_W-1:0] STEP    = ACC_W'(1 << FRAC_BITS);
    localparam logic [ACC_W-1:0] REM_MAX = ACC_W'((1 << FRAC_BITS) - 1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             pix;
    } nco_t;

    nco_t             nco_d, nco_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] rem;

    always_comb begin
        nco_d = nco_q;
        sum   = nco_q.acc + STEP;
        rem   = sum - {1'b0, div_i};
        if (clr) begin
            nco_d.acc = '0;
            nco_d.pix = 1'b0;
        end else if (sum >= {1'b0, div_i}) begin
            // period complete: carry the fraction, capped below one step
            nco_d.pix = 1'b1;
            nco_d.acc = (rem > REM_MAX) ? REM_MAX : rem;
        end else begin
            nco_d.pix = 1'b0;
            nco_d.acc = sum;
        end
    end

    always_ff @(posedge clk) begin
        nco_q <= nco_d;
    end

    assign pix_en_o = nco_q.pix;
endmodule

// File: rtl/lpll_meter.sv
module lpll_meter #(
    parameter int LD_W  = 6,
    parameter int CNT_W = 11
) (
    input  logic                    clk,
    input  logic                    clr,
    input  logic                    hsync_i,
    input  logic                    pix_en_i,
    input  logic [LD_W-1:0]         line_len_i,
    output logic                    meas_vld_o,
    output logic signed [CNT_W:0]   meas_err_o
);
    import lpll_pkg::*;

    localparam int ERR_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = '1;

    typedef struct packed {
        logic                    hs;
        logic [CNT_W-1:0]        cnt;
        logic                    primed;
        logic                    vld;
        logic signed [ERR_W-1:0] err;
    } meter_t;

    meter_t           mtr_d, mtr_q;
    logic             rise;
    logic [CNT_W-1:0] line_px;
    logic [CNT_W-1:0] target;

    always_comb begin
        target  = CNT_W'(PX_PER_UNIT * (2 * int'(line_len_i) + 1));
        rise    = hsync_i & ~mtr_q.hs;
        line_px = (pix_en_i && (mtr_q.cnt != CNT_FULL)) ? mtr_q.cnt + 1'b1 : mtr_q.cnt;

        mtr_d     = mtr_q;
        mtr_d.hs  = hsync_i;
        mtr_d.vld = 1'b0;
        if (clr) begin
            mtr_d.cnt    = '0;
            mtr_d.primed = 1'b0;
            mtr_d.err    = '0;
        end else if (rise) begin
            mtr_d.cnt    = '0;
            mtr_d.vld    = mtr_q.primed;
            mtr_d.err    = $signed({1'b0, line_px}) - $signed({1'b0, target});
            mtr_d.primed = 1'b1;
        end else begin
            mtr_d.cnt = line_px;
        end
    end

    always_ff @(posedge clk) begin
        mtr_q <= mtr_d;
    end

    assign meas_vld_o = mtr_q.vld;
    assign meas_err_o = mtr_q.err;
endmodule

// File: rtl/lpll_loop.sv
module lpll_loop #(
    parameter int D_W        = 8,
    parameter int PP_W       = 8,
    parameter int K_W        = 3,
    parameter int ERR_W      = 12,
    parameter int D_MIN      = 20,
    parameter int D_MAX      = 128,
    parameter int TOL        = 2,
    parameter int LOCK_LINES = 4
) (
    input  logic                    clk,
    input  logic                    clr,
    input  logic [PP_W-1:0]         pp_i,
    input  logic                    meas_vld_i,
    input  logic signed [ERR_W-1:0] meas_err_i,
    input  logic [K_W-1:0]          lock_a_i,
    input  logic [K_W-1:0]          lock_b_i,
    input  logic [K_W-1:0]          cap_a_i,
    input  logic [K_W-1:0]          cap_b_i,
    output logic [D_W-1:0]          div_o,
    output logic                    locked_o
);
    import lpll_pkg::*;

    localparam int GOOD_W = $clog2(LOCK_LINES + 1);
    localparam int SUM_W  = ((ERR_W > D_W) ? ERR_W : D_W) + 3;
    localparam logic signed [SUM_W-1:0] LO    = SUM_W'(D_MIN);
    localparam logic signed [SUM_W-1:0] HI    = SUM_W'(D_MAX);
    localparam logic signed [ERR_W-1:0] TOL_P = ERR_W'(TOL);
    localparam logic [GOOD_W-1:0] GOOD_FULL   = GOOD_W'(LOCK_LINES);

    typedef struct packed {
        logic [D_W-1:0]          div;
        logic signed [ERR_W-1:0] eprev;
        logic [GOOD_W-1:0]       good;
        loop_mode_e              mode;
    } loop_t;

    loop_t                   lp_d, lp_q;
    logic [K_W-1:0]          sh_a, sh_b;
    logic signed [ERR_W-1:0] prop_t;
    logic signed [ERR_W:0]   diff, diff_t;
    logic signed [SUM_W-1:0] sum;
    logic                    in_tol;
    logic [GOOD_W-1:0]       good_n;

    always_comb begin
        sh_a   = (lp_q.mode == MODE_LOCK) ? lock_a_i : cap_a_i;
        sh_b   = (lp_q.mode == MODE_LOCK) ? lock_b_i : cap_b_i;
        prop_t = meas_err_i >>> sh_a;
        diff   = {meas_err_i[ERR_W-1], meas_err_i} - {lp_q.eprev[ERR_W-1], lp_q.eprev};
        diff_t = diff >>> sh_b;
        sum    = $signed({{(SUM_W-D_W){1'b0}}, lp_q.div}) + SUM_W'(prop_t) + SUM_W'(diff_t);
        in_tol = (meas_err_i <= TOL_P) && (meas_err_i >= -TOL_P);
        if (!in_tol) begin
            good_n = '0;
        end else if (lp_q.good == GOOD_FULL) begin
            good_n = lp_q.good;
        end else begin
            good_n = lp_q.good + 1'b1;
        end

        lp_d = lp_q;
        if (clr) begin
            if (int'(pp_i) < D_MIN) begin
                lp_d.div = D_W'(D_MIN);
            end else if (int'(pp_i) > D_MAX) begin
                lp_d.div = D_W'(D_MAX);
            end else begin
                lp_d.div = D_W'(pp_i);
            end
            lp_d.eprev = '0;
            lp_d.good  = '0;
            lp_d.mode  = MODE_CAPTURE;
        end else if (meas_vld_i) begin
            if (sum < LO) begin
                lp_d.div = D_W'(D_MIN);
            end else if (sum > HI) begin
                lp_d.div = D_W'(D_MAX);
            end else begin
                lp_d.div = sum[D_W-1:0];
            end
            lp_d.eprev = meas_err_i;
            lp_d.good  = good_n;
            lp_d.mode  = (good_n == GOOD_FULL) ? MODE_LOCK : MODE_CAPTURE;
        end
    end

    always_ff @(posedge clk) begin
        lp_q <= lp_d;
    end

    assign div_o    = lp_q.div;
    assign locked_o = (lp_q.mode == MODE_LOCK);
endmodule

// File: rtl/line_lock_pll.sv
module line_lock_pll #(
    parameter int LD_W       = lpll_pkg::LD_W_DEF,
    parameter int PP_W       = lpll_pkg::PP_W_DEF,
    parameter int K_W        = lpll_pkg::K_W_DEF,
    parameter int FRAC_BITS  = lpll_pkg::FRAC_BITS_DEF,
    parameter int D_MIN      = lpll_pkg::D_MIN_DEF,
    parameter int D_MAX      = lpll_pkg::D_MAX_DEF,
    parameter int LOCK_TOL   = lpll_pkg::TOL_DEF,
    parameter int LOCK_LINES = lpll_pkg::LOCK_LINES_DEF,
    parameter int CNT_W      = lpll_pkg::CNT_W_DEF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          hsync,
    input  logic [LD_W-1:0]               line_len,
    input  logic [PP_W-1:0]               pp_val,
    input  logic                          pp_wr,
    input  logic [K_W-1:0]                lock_a,
    input  logic [K_W-1:0]                lock_b,
    input  logic [K_W-1:0]                cap_a,
    input  logic [K_W-1:0]                cap_b,
    output logic                          pix_en,
    output logic                          locked,
    output logic [$clog2(D_MAX+1)-1:0]    div
);
    localparam int D_W   = $clog2(D_MAX + 1);
    localparam int ERR_W = CNT_W + 1;

    logic                    clr;
    logic                    meas_vld;
    logic signed [ERR_W-1:0] meas_err;

    assign clr = rst | pp_wr;

    lpll_nco #(
        .D_W       (D_W),
        .FRAC_BITS (FRAC_BITS)
    ) u_nco (
        .clk      (clk),
        .clr      (clr),
        .div_i    (div),
        .pix_en_o (pix_en)
    );

    lpll_meter #(
        .LD_W  (LD_W),
        .CNT_W (CNT_W)
    ) u_meter (
        .clk        (clk),
        .clr        (clr),
        .hsync_i    (hsync),
        .pix_en_i   (pix_en),
        .line_len_i (line_len),
        .meas_vld_o (meas_vld),
        .meas_err_o (meas_err)
    );

    lpll_loop #(
        .D_W        (D_W),
        .PP_W       (PP_W),
        .K_W        (K_W),
        .ERR_W      (ERR_W),
        .D_MIN      (D_MIN),
        .D_MAX      (D_MAX),
        .TOL        (LOCK_TOL),
        .LOCK_LINES (LOCK_LINES)
    ) u_loop (
        .clk        (clk),
        .clr        (clr),
        .pp_i       (pp_val),
        .meas_vld_i (meas_vld),
        .meas_err_i (meas_err),
        .lock_a_i   (lock_a),
        .lock_b_i   (lock_b),
        .cap_a_i    (cap_a),
        .cap_b_i    (cap_b),
        .div_o      (div),
        .locked_o   (locked)
    );
endmodule

// File: rtl/line_lock_pll_chk.sv
module line_lock_pll_chk #(
    parameter int D_W       = 8,
    parameter int PP_W      = 8,
    parameter int ERR_W     = 12,
    parameter int FRAC_BITS = 3,
    parameter int D_MIN     = 20,
    parameter int D_MAX     = 128,
    parameter int TOL       = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    pp_wr,
    input logic [PP_W-1:0]         pp_val,
    input logic                    pix_en,
    input logic                    locked,
    input logic [D_W-1:0]          div,
    input logic                    meas_vld,
    input logic signed [ERR_W-1:0] meas_err
);
    localparam int STEP    = 1 << FRAC_BITS;
    localparam int MAX_GAP = (D_MAX + STEP - 1) / STEP;
    localparam int GAP_W   = $clog2(MAX_GAP + 2) + 1;
    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MAX_GAP);
    localparam logic signed [ERR_W-1:0] TOL_P = ERR_W'(TOL);

    logic [GAP_W-1:0] gap_q;
    logic [D_W-1:0]   load_exp;

    always_ff @(posedge clk) begin
        if (rst || pp_wr) begin
            gap_q <= '0;
        end else if (pix_en) begin
            gap_q <= GAP_W'(1);
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    always_comb begin
        if (int'(pp_val) < D_MIN) begin
            load_exp = D_W'(D_MIN);
        end else if (int'(pp_val) > D_MAX) begin
            load_exp = D_W'(D_MAX);
        end else begin
            load_exp = D_W'(pp_val);
        end
    end

    // R2
    pix_gap_min_chk: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> !pix_en);

    // R2
    pix_gap_max_chk: assert property (@(posedge clk) disable iff (rst)
        gap_q <= GAP_LIM);

    // R4
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(div) >= D_MIN) && (int'(div) <= D_MAX));

    // R9
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!meas_vld && !pp_wr) |=> $stable(div));

    // R8
    load_apply_chk: assert property (@(posedge clk) disable iff (rst)
        pp_wr |=> (!locked && (div == $past(load_exp))));

    // R6
    unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (meas_vld && !pp_wr && ((meas_err > TOL_P) || (meas_err < -TOL_P))) |=> !locked);

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(meas_vld));
endmodule

bind line_lock_pll line_lock_pll_chk #(
    .D_W       (D_W),
    .PP_W      (PP_W),
    .ERR_W     (ERR_W),
    .FRAC_BITS (FRAC_BITS),
    .D_MIN     (D_MIN),
    .D_MAX     (D_MAX),
    .TOL       (LOCK_TOL)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pp_wr    (pp_wr),
    .pp_val   (pp_val),
    .pix_en   (pix_en),
    .locked   (locked),
    .div      (div),
    .meas_vld (meas_vld),
    .meas_err (meas_err)
);

// File: tb/line_lock_pll_bench.sv
module line_lock_pll_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       hsync;
    logic [5:0] line_len;
    logic [7:0] pp_val;
    logic       pp_wr;
    logic [2:0] lock_a, lock_b, cap_a, cap_b;
    logic       pix_en;
    logic       locked;
    logic [7:0] div;

    always #10 clk = ~clk;

    line_lock_pll u_line_lock_pll (
        .clk      (clk),
        .rst      (rst),
        .hsync    (hsync),
        .line_len (line_len),
        .pp_val   (pp_val),
        .pp_wr    (pp_wr),
        .lock_a   (lock_a),
        .lock_b   (lock_b),
        .cap_a    (cap_a),
        .cap_b    (cap_b),
        .pix_en   (pix_en),
        .locked   (locked),
        .div      (div)
    );

    int total = 0;
    int bad   = 0;

    typedef struct {
        int    due;
        int    dv;
        bit    lk;
        string tag;
    } exp_t;
    exp_t sbq[$];

    // reference state, built from port observations only
    int m_div, m_eprev, m_good, m_cnt, win, gap, last_gap;
    bit m_lock, m_primed, hs_prev, gap_valid, cur_valid;
    int cur_div;
    bit cur_lk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampi(input int v);
        if (v < 20) return 20;
        if (v > 128) return 128;
        return v;
    endfunction

    task automatic push_exp(input int due, input int dv, input bit lk, input string tag);
        exp_t e;
        e.due = due; e.dv = dv; e.lk = lk; e.tag = tag;
        sbq.push_back(e);
    endtask

    // monitor / predictor: samples in the middle of each cycle
    initial begin
        win = 0; gap = 0; gap_valid = 0; cur_valid = 0; hs_prev = 0; m_cnt = 0;
        m_primed = 0; m_lock = 0; m_good = 0; m_eprev = 0; m_div = 0; last_gap = 0;
        forever begin
            @(negedge clk);
            #1;
            win++;
            begin
                bit popped;
                string tg;
                popped = 0;
                tg = "R9";
                while (sbq.size() > 0 && sbq[0].due == win) begin
                    exp_t e;
                    e = sbq.pop_front();
                    cur_div = e.dv; cur_lk = e.lk; cur_valid = 1; tg = e.tag; popped = 1;
                end
                if (cur_valid) begin
                    check(int'(div) == cur_div, {tg, " div"}, int'(div), cur_div);
                    check(locked == cur_lk, {tg, " locked"}, int'(locked), int'(cur_lk));
                end
                if (popped) begin end
            end
            // R2 pulse spacing
            gap++;
            if (pix_en) begin
                if (gap_valid) check(gap >= 2 && gap <= 16, "R2 gap", gap, 2);
                last_gap = gap;
                gap = 0;
                gap_valid = 1;
            end
            // prediction
            if (rst || pp_wr) begin
                m_div = clampi(int'(pp_val));
                m_lock = 0; m_good = 0; m_primed = 0; m_eprev = 0; m_cnt = 0;
                gap_valid = 0;
                push_exp(win + 1, m_div, 1'b0, "R8");
            end else if (hsync && !hs_prev) begin
                int line_px;
                line_px = m_cnt + int'(pix_en);
                m_cnt = 0;
                if (m_primed) begin
                    int err, a, b, s;
                    err = line_px - 12 * (2 * int'(line_len) + 1);  // R1
                    a = m_lock ? int'(lock_a) : int'(cap_a);        // R7
                    b = m_lock ? int'(lock_b) : int'(cap_b);
                    s = m_div + (err >>> a) + ((err - m_eprev) >>> b);
                    m_div = clampi(s);
                    m_eprev = err;
                    if (err <= 2 && err >= -2) m_good = (m_good < 4) ? m_good + 1 : 4;
                    else m_good = 0;
                    m_lock = (m_good == 4);
                    push_exp(win + 2, m_div, m_lock, "R3");
                end else begin
                    m_primed = 1;
                    push_exp(win + 2, m_div, m_lock, "R10");
                end
            end else begin
                m_cnt += int'(pix_en);
            end
            hs_prev = hsync;
        end
    end

    // driver tasks
    task automatic run_line(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            hsync = (i < 4);
        end
    endtask

    task automatic load_pp(input int v);
        @(negedge clk);
        pp_val = 8'(v);
        pp_wr = 1'b1;
        @(negedge clk);
        pp_wr = 1'b0;
        #2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; hsync = 1'b0; line_len = 6'd1; pp_val = 8'd40; pp_wr = 1'b0;
        lock_a = 3'd1; lock_b = 3'd2; cap_a = 3'd0; cap_b = 3'd1;
        repeat (2) @(negedge clk);
        #2;
        // R8: reset state
        check(int'(div) == 40, "R8 reset div", int'(div), 40);
        check(locked == 1'b0, "R8 reset locked", int'(locked), 0);
        check(pix_en == 1'b0, "R8 reset pix_en", int'(pix_en), 0);
        @(negedge clk);
        rst = 1'b0;

        // line_len=1 -> 36 pixels; div=40 gives exactly 36 per 180 cycles
        for (int i = 0; i < 4; i++) run_line(180);
        #2;
        check(locked == 1'b0, "R5 three good lines", int'(locked), 0);
        check(int'(div) == 40, "R1 zero error keeps div", int'(div), 40);
        run_line(180);
        #2;
        check(locked == 1'b1, "R5 four good lines", int'(locked), 1);
        check(last_gap == 5, "R2 spacing div/8", last_gap, 5);

        // 200-cycle line -> 40 pixels, err=+4 while locked: 40+(4>>>1)+(4>>>2)=43
        run_line(200);
        run_line(180);
        #2;
        check(int'(div) == 43, "R7 lock constants", int'(div), 43);
        check(locked == 1'b0, "R6 bad line unlocks", int'(locked), 0);
        for (int i = 0; i < 6; i++) run_line(200);

        // R8: loads clamp to range
        load_pp(250);
        check(int'(div) == 128, "R8 load high clamp", int'(div), 128);
        check(locked == 1'b0, "R8 load clears lock", int'(locked), 0);
        load_pp(5);
        check(int'(div) == 20, "R8 load low clamp", int'(div), 20);

        // saturation at both ends
        load_pp(128);
        line_len = 6'd40;
        run_line(180);
        #2;
        check(int'(div) == 128, "R10 first edge only primes", int'(div), 128);
        run_line(180);
        #2;
        check(int'(div) == 20, "R4 low saturation", int'(div), 20);
        line_len = 6'd0;
        run_line(180);
        #2;
        check(int'(div) == 128, "R4 high saturation", int'(div), 128);

        // reset mid-run, then capture again from pp_val
        @(negedge clk);
        pp_val = 8'd40;
        line_len = 6'd1;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #2;
        check(int'(div) == 40, "R8 reset reload", int'(div), 40);
        for (int i = 0; i < 6; i++) run_line(180);
        #2;
        check(locked == 1'b1, "R5 relock after reset", int'(locked), 1);
        repeat (4) @(negedge clk);
        #2;
        check(sbq.size() == 0, "R3 all updates seen", sbq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule